// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between a synchronous requester and an external asynchronous static RAM with 131,072 words of 8 bits. Each request on a valid/ready port asks for one word, either read or written. The controller turns that request into a timed sequence of active-low chip-enable, write-enable and output-enable strobes, a held address and a split tri-state data bus. The bus is split into the value to drive, a drive enable for the pad, and the value sampled from the pad. Every phase of the sequence lasts a parameterised number of clock cycles, so the memory's setup, pulse-width, hold and bus-release times can be met at any clock rate.

The port follows valid/ready rules. A request transfers on the rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. While `req_ready` is low, the requester must keep `req_valid` high and its fields unchanged; this is how back-pressure works. Read data comes back with a single-cycle `rsp_valid` pulse. The response side has no back-pressure, because only one read can be in flight.

The sequencing keeps the two drivers of the data bus apart. The controller drives the bus only while output enable is high toward the memory. It also waits for a release interval after any memory drive before driving again, and it keeps data and address stable past the write-enable edge that ends a write. Chip enable is deasserted whenever the controller is idle, so the memory stays in its low-power state.

Top module: `asram_port_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all three strobes are high, the bus drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted only on a cycle where `req_valid` and `req_ready` are both high. From the next cycle `req_ready` stays low until the sequence for that request is complete, and a request held pending meanwhile is accepted on the first cycle `req_ready` returns high.
- R3: After an accepted read, the next READ_CYCLES cycles have chip enable low, output enable low and write enable high, with the address bus equal to the request address.
- R4: The bus input is sampled on the clock edge that ends the last read-wait cycle. In the following cycle `rsp_valid` is high for exactly one cycle with that value on `rsp_rdata`, and all strobes are high.
- R5: After the response cycle of a read, the controller spends TURNAROUND_CYCLES cycles with all strobes high and the bus undriven before `req_ready` returns high.
- R6: After an accepted write, chip enable and write enable are low and output enable is high for TURNAROUND_CYCLES + WE_PULSE_CYCLES cycles. The bus is undriven for the first TURNAROUND_CYCLES of these and driven with the request data for the last WE_PULSE_CYCLES.
- R7: After write enable rises, HOLD_CYCLES cycles follow with chip enable low, output enable high, and the bus still driven with unchanged data and address. Then the controller returns to idle.
- R8: The controller never drives the bus on a cycle where output enable is low, so it and the memory never drive the bus at the same time.
- R9: Whenever the controller is idle, chip enable is high and the bus is undriven.
- R10: `rsp_valid` never rises during a write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 8 | Read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 17 | Memory address lines |
| mem_dq_out | output | 8 | Value to drive onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data-bus pads |
| mem_dq_in | input | 8 | Value sampled from the data-bus pads |

## Verification
The assertions assume that the requester respects the valid/ready rules: once `req_valid` is high it stays high, with `req_write`, `req_addr` and `req_wdata` unchanged, until it is accepted. They also assume that `mem_dq_in` is settled by the edge that ends the read wait. The stimulus raises a request only at a falling edge and keeps it, unchanged, until the edge where it is accepted. It issues requests back to back, so the hold rule is exercised under real back-pressure. The bench memory drives `mem_dq_in` only for a legal read combination of strobes, so the sampled value always comes from a settled bus.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_WAIT  = 3'd1,
    ST_RD_TAKE  = 3'd2,
    ST_WR_SETUP = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_HOLD  = 3'd5,
    ST_TURN     = 3'd6
  } asram_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } asram_strobes_t;

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

  assert_load_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/asram_sequencer.sv
module asram_sequencer
  import asram_pkg::*;
#(
  parameter int READ_CYCLES       = 2,
  parameter int WE_PULSE_CYCLES   = 1,
  parameter int TURNAROUND_CYCLES = 1,
  parameter int HOLD_CYCLES       = 1,
  parameter int CNT_W             = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             req_write,
  input  logic             phase_last,
  output asram_state_e     state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(READ_CYCLES - 1);
  localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WE_PULSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] TA_LOAD   = CNT_W'(TURNAROUND_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES - 1);

  asram_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_fire) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR_SETUP;
            tmr_val = TA_LOAD;
          end else begin
            state_d = ST_RD_WAIT;
            tmr_val = RD_LOAD;
          end
        end
      end
      ST_RD_WAIT: begin
        if (phase_last) state_d = ST_RD_TAKE;
      end
      ST_RD_TAKE: begin
        state_d  = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = TA_LOAD;
      end
      ST_TURN: begin
        if (phase_last) state_d = ST_IDLE;
      end
      ST_WR_SETUP: begin
        if (phase_last) begin
          state_d  = ST_WR_PULSE;
          tmr_load = 1'b1;
          tmr_val  = WP_LOAD;
        end
      end
      ST_WR_PULSE: begin
        if (phase_last) begin
          state_d  = ST_WR_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LOAD;
        end
      end
      ST_WR_HOLD: begin
        if (phase_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  assert_take_then_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_TAKE) |=> (state_q == ST_TURN));

  assert_pulse_after_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR_PULSE) |-> ($past(state_q) == ST_WR_SETUP || $past(state_q) == ST_WR_PULSE));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_req,
  input  logic              take_bus,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take_req) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (take_bus) rdata_q <= bus_in;
  end

endmodule

// File: rtl/asram_port_ctrl.sv
module asram_port_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W            = 17,
  parameter int DATA_W            = 8,
  parameter int READ_CYCLES       = 2,
  parameter int WE_PULSE_CYCLES   = 1,
  parameter int TURNAROUND_CYCLES = 1,
  parameter int HOLD_CYCLES       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int MAX_AB    = (READ_CYCLES > WE_PULSE_CYCLES) ? READ_CYCLES : WE_PULSE_CYCLES;
  localparam int MAX_CD    = (TURNAROUND_CYCLES > HOLD_CYCLES) ? TURNAROUND_CYCLES : HOLD_CYCLES;
  localparam int MAX_PHASE = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W     = $clog2(MAX_PHASE + 1);

  asram_state_e     state;
  asram_strobes_t   strb;
  logic             req_fire;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;
  logic             take_bus;

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign take_bus  = (state == ST_RD_WAIT) && tmr_last;

  asram_sequencer #(
    .READ_CYCLES      (READ_CYCLES),
    .WE_PULSE_CYCLES  (WE_PULSE_CYCLES),
    .TURNAROUND_CYCLES(TURNAROUND_CYCLES),
    .HOLD_CYCLES      (HOLD_CYCLES),
    .CNT_W            (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .req_write (req_write),
    .phase_last(tmr_last),
    .state     (state),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val)
  );

  asram_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .last    (tmr_last)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_req (req_fire),
    .take_bus (take_bus),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .bus_in   (mem_dq_in),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dq_out),
    .rdata_q  (rsp_rdata)
  );

  always_comb begin
    strb = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    case (state)
      ST_RD_WAIT:  strb = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      ST_WR_SETUP: strb = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b0};
      ST_WR_PULSE: strb = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
      ST_WR_HOLD:  strb = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      default: ;
    endcase
  end

  assign mem_ce_n  = strb.ce_n;
  assign mem_we_n  = strb.we_n;
  assign mem_oe_n  = strb.oe_n;
  assign mem_dq_oe = strb.dq_oe;
  assign rsp_valid = (state == ST_RD_TAKE);

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_idle_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_dq_oe));

  assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_write_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (!mem_ce_n && mem_oe_n && !mem_dq_oe));

  assert_data_past_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

  assert_drive_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> ($stable(mem_dq_out) && $stable(mem_addr)));

  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_no_rsp_in_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !rsp_valid);

endmodule

// File: tb/asram_port_ctrl_test.sv
module asram_port_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int RD  = 3;
  localparam int WP  = 2;
  localparam int TA  = 2;
  localparam int HD  = 2;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_port_ctrl #(
    .READ_CYCLES(RD), .WE_PULSE_CYCLES(WP), .TURNAROUND_CYCLES(TA), .HOLD_CYCLES(HD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit running  = 0;
  bit finished = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural memory: drives only on a legal read combination
  logic [7:0] bmem [int];
  logic [7:0] shadow [int];
  logic       mem_drives;
  logic       wr_pending = 1'b0;
  logic [16:0] wr_addr;
  logic [7:0]  wr_data;

  assign mem_drives = !mem_ce_n && !mem_oe_n && mem_we_n;
  always @* begin
    if (mem_drives) mem_dq_in = bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;
    else            mem_dq_in = 8'h00;
  end

  always @(negedge clk) if (running) begin
    check("R8", "both_drive", {31'd0, mem_drives && mem_dq_oe}, 32'd0);
    if (!mem_ce_n && !mem_we_n) begin
      if (mem_dq_oe) begin
        wr_pending = 1'b1;
        wr_addr    = mem_addr;
        wr_data    = mem_dq_out;
      end
    end else if (wr_pending) begin
      wr_pending = 1'b0;
      bmem[int'(wr_addr)] = (mem_dq_oe && mem_dq_out == wr_data) ? wr_data : 8'hxx;
    end
  end

  // cycle-by-cycle reference expectations
  typedef struct {
    logic ce, we, oe, dqoe, rdy, rv;
    logic [16:0] addr;
    logic [7:0]  data;
    string tag;
  } exp_t;

  exp_t expq[$];

  function automatic exp_t mk(logic ce, logic we, logic oe, logic dqoe, logic rdy,
                              logic rv, logic [16:0] a, logic [7:0] d, string tag);
    exp_t e;
    e.ce = ce; e.we = we; e.oe = oe; e.dqoe = dqoe; e.rdy = rdy; e.rv = rv;
    e.addr = a; e.data = d; e.tag = tag;
    return e;
  endfunction

  always @(negedge clk) if (running) begin
    exp_t e;
    if (expq.size() > 0) e = expq.pop_front();
    else                 e = mk(1, 1, 1, 0, 1, 0, '0, '0, "R9");
    check(e.tag, "ce_n", {31'd0, mem_ce_n}, {31'd0, e.ce});
    check(e.tag, "we_n", {31'd0, mem_we_n}, {31'd0, e.we});
    check(e.tag, "oe_n", {31'd0, mem_oe_n}, {31'd0, e.oe});
    check(e.tag, "dq_oe", {31'd0, mem_dq_oe}, {31'd0, e.dqoe});
    check("R2", "ready", {31'd0, req_ready}, {31'd0, e.rdy});
    check((e.tag == "R6" || e.tag == "R7") ? "R10" : "R4", "rsp_valid",
          {31'd0, rsp_valid}, {31'd0, e.rv});
    if (!e.ce) check(e.tag, "addr", {15'd0, mem_addr}, {15'd0, e.addr});
    if (e.dqoe) check(e.tag, "dq_out", {24'd0, mem_dq_out}, {24'd0, e.data});
    if (e.rv) check("R4", "rdata", {24'd0, rsp_rdata}, {24'd0, e.data});
  end

  task automatic issue(input bit w, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_wdata = ~d;
    req_addr  = ~a;
    if (w) begin
      shadow[int'(a)] = d;
      for (int i = 0; i < TA; i++) expq.push_back(mk(0, 0, 1, 0, 0, 0, a, d, "R6"));
      for (int i = 0; i < WP; i++) expq.push_back(mk(0, 0, 1, 1, 0, 0, a, d, "R6"));
      for (int i = 0; i < HD; i++) expq.push_back(mk(0, 1, 1, 1, 0, 0, a, d, "R7"));
    end else begin
      logic [7:0] x;
      x = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      for (int i = 0; i < RD; i++) expq.push_back(mk(0, 1, 0, 0, 0, 0, a, x, "R3"));
      expq.push_back(mk(1, 1, 1, 0, 0, 1, a, x, "R4"));
      for (int i = 0; i < TA; i++) expq.push_back(mk(1, 1, 1, 0, 0, 0, a, x, "R5"));
    end
  endtask

  task automatic drain();
    while (expq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "ce_n", {31'd0, mem_ce_n}, 32'd1);
    check("R1", "we_n", {31'd0, mem_we_n}, 32'd1);
    check("R1", "oe_n", {31'd0, mem_oe_n}, 32'd1);
    check("R1", "dq_oe", {31'd0, mem_dq_oe}, 32'd0);
    check("R1", "ready", {31'd0, req_ready}, 32'd1);
    check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    running = 1;
    @(negedge clk);

    issue(1, 17'h00000, 8'hA5);
    drain();
    issue(1, 17'h1FFFF, 8'h3C);
    drain();
    issue(0, 17'h00000, 8'h00);
    drain();
    issue(0, 17'h1FFFF, 8'h00);
    drain();
    // back-to-back: held requests wait on ready (R2)
    issue(1, 17'h0ABCD, 8'h5A);
    issue(0, 17'h0ABCD, 8'h00);
    issue(1, 17'h0ABCD, 8'hFF);
    issue(0, 17'h0ABCD, 8'h00);
    issue(1, 17'h12345, 8'h00);
    issue(0, 17'h12345, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    drain();
    repeat (3) @(negedge clk);
    running = 0;
    summary();
  end

endmodule